// File: doc/BRIEF.md
# Configuration Request Header Formatter

This block sits between a CPU-side register bus and the transaction layer of a PCIe root-port bridge. Software first programs a routing register with the target bus number, the device/function number, a byte-enable pattern and an override flag. It then reads or writes a 4 KB configuration window. Each window access is turned into one configuration request: the routing fields come from the programmed register, the register number comes from the window offset, and the first-dword byte enables and lane-aligned write data come from the access size and offset.

Only one request is in flight at a time. Once an access is accepted, the bus interface stalls until the transaction layer has answered and the response has been handed back. The read data returned to the CPU is always the whole dword, and the requester extracts any narrower field itself. Accesses to the routing register complete locally without touching the transaction layer.

Top module: `cfghdr_fmt`

## Requirements
- R1: After reset `rb_ready` is 1, `tl_req` and `rb_done` are 0, and the routing register reads back as zero.
- R2: A write to offset 0x140 stores data bits 20:0 in the routing register: devfn in bits 7:0, bus in bits 15:8, programmed byte enables in bits 19:16 and the override flag in bit 20. A read returns those 21 bits, and bits 31:21 read as 0.
- R3: An access whose address has bit 12 set (offsets 0x1000 to 0x1FFF) raises `tl_req` in the cycle after acceptance. In that request `tl_bus` and `tl_devfn` come from the routing register, `tl_regnum` is address bits 11:2, and `tl_write` is the access direction.
- R4: With the override flag clear, `tl_first_be` is a mask of `rb_size` ones (sizes 1, 2 or 4 bytes) shifted left by address bits 1:0 and truncated to 4 bits, so a 4-byte access at offset 0 gives 4'b1111 and a 2-byte access at offset 3 gives 4'b1000.
- R5: With the override flag set, `tl_first_be` equals routing register bits 19:16, whatever the access size and offset.
- R6: For sizes of 2 bytes or less, `tl_wdata` is `rb_wdata` shifted left by 8 times address bits 1:0 and truncated to 32 bits. For a 4-byte size it is `rb_wdata` unchanged.
- R7: When `tl_done` is sampled high during a request, `rb_done` is high in the next cycle. For a read, `rb_rdata` then holds the full 32-bit `tl_rdata` sampled with `tl_done`. For a write, it holds 0.
- R8: From acceptance until the cycle after `rb_done`, `rb_ready` is 0. While `tl_req` is high and `tl_done` is low, `tl_req` stays high and every request field holds its value.
- R9: An access to any address that is neither 0x140 nor in the window is completed with `rb_done`. It changes no state, and a read of such an address returns 0.
- R10: An access to the routing register raises `rb_done` in the cycle after acceptance, and `rb_ready` returns one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rb_valid | input | 1 | Register bus access request |
| rb_write | input | 1 | 1 = write, 0 = read |
| rb_addr | input | 13 | Byte address of the access |
| rb_size | input | 3 | Access size in bytes (1, 2 or 4) |
| rb_wdata | input | 32 | Write data, right-aligned for narrow writes |
| rb_ready | output | 1 | Block can accept an access this cycle |
| rb_done | output | 1 | One-cycle completion strobe |
| rb_rdata | output | 32 | Read data, valid with `rb_done` |
| tl_req | output | 1 | Configuration request pending toward the transaction layer |
| tl_write | output | 1 | Request is a configuration write |
| tl_bus | output | 8 | Target bus number |
| tl_devfn | output | 8 | Target device/function number |
| tl_regnum | output | 10 | Dword-aligned register number |
| tl_first_be | output | 4 | First-dword byte enables |
| tl_wdata | output | 32 | Lane-aligned write data |
| tl_done | input | 1 | Transaction layer completion strobe |
| tl_rdata | input | 32 | Completion data, valid with `tl_done` |

## Verification
The assertions assume that the transaction layer pulses `tl_done` only while `tl_req` is high, and that `rb_size` carries 1, 2 or 4 on a window access. The bench's responder drives `tl_done` for a single cycle, and only after it has seen `tl_req` at a falling edge. The driver presents each access only while `rb_ready` is high and only with legal sizes. As a result, the hold-off and field-stability properties are exercised under variable completion delays and never against illegal stimulus.

// File: rtl/cfghdr_pkg.sv
package cfghdr_pkg;

   // Routing register layout; field order is fixed by what software programs.
   localparam int HDR_DEVFN_LSB = 0;
   localparam int HDR_BUS_LSB   = 8;
   localparam int HDR_BE_LSB    = 16;
   localparam int HDR_OVR_BIT   = 20;
   localparam int HDR_USED_W    = 21;

   localparam int SIZE_W        = 3;

   typedef struct packed {
      logic       ovr;
      logic [3:0] be;
      logic [7:0] bus;
      logic [7:0] devfn;
   } hdr_t;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_WAIT = 2'd1,
      PH_RESP = 2'd2
   } phase_e;

endpackage

// File: rtl/cfghdr_reg.sv
module cfghdr_reg
   import cfghdr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [HDR_USED_W-1:0] wr_data,
   output hdr_t                  hdr_q,
   output logic [DATA_W-1:0]     rd_view
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_q <= '0;
      end else if (wr_en) begin
         hdr_q <= hdr_t'(wr_data);
      end
   end

   always_comb begin
      rd_view                   = '0;
      rd_view[HDR_USED_W-1:0]   = hdr_q;
   end

endmodule

// File: rtl/cfghdr_lane.sv
module cfghdr_lane #(
   parameter int NLANE  = 4,
   parameter int IDX_W  = 2,
   parameter int SIZE_W = 3
) (
   input  logic [SIZE_W-1:0]  acc_size,
   input  logic [IDX_W-1:0]   acc_lo,
   input  logic [8*NLANE-1:0] acc_wdata,
   output logic [NLANE-1:0]   be_auto,
   output logic [8*NLANE-1:0] wdata_al
);

   localparam int NARROW_MAX = 2;

   logic shift_en;
   assign shift_en = (int'(acc_size) <= NARROW_MAX);

   for (genvar i = 0; i < NLANE; i++) begin : g_lane
      logic [7:0] lane_b;

      // Lane i is enabled when it lies in [lo, lo+size); lanes past the top drop.
      assign be_auto[i] = (int'(acc_lo) <= i) && (i < int'(acc_lo) + int'(acc_size));

      // Source byte k moves to lane k+lo for narrow accesses.
      always_comb begin
         lane_b = '0;
         for (int k = 0; k <= i; k++) begin
            if (int'(acc_lo) == i - k) begin
               lane_b = acc_wdata[8*k +: 8];
            end
         end
      end

      assign wdata_al[8*i +: 8] = shift_en ? lane_b : acc_wdata[8*i +: 8];
   end

endmodule

// File: rtl/cfghdr_ctl.sv
module cfghdr_ctl
   import cfghdr_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NLANE    = 4,
   parameter int REGNUM_W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_fire,
   input  logic                hit_hdr,
   input  logic                hit_win,
   input  logic                acc_write,
   input  logic [REGNUM_W-1:0] acc_regnum,
   input  hdr_t                hdr_q,
   input  logic [DATA_W-1:0]   hdr_view,
   input  logic [NLANE-1:0]    be_auto,
   input  logic [DATA_W-1:0]   wdata_al,
   input  logic                tl_done,
   input  logic [DATA_W-1:0]   tl_rdata,
   output phase_e              phase,
   output logic                hdr_we,
   output logic                tl_write,
   output logic [7:0]          tl_bus,
   output logic [7:0]          tl_devfn,
   output logic [REGNUM_W-1:0] tl_regnum,
   output logic [NLANE-1:0]    tl_be,
   output logic [DATA_W-1:0]   tl_wdata,
   output logic [DATA_W-1:0]   rsp_data
);

   logic [NLANE-1:0] be_sel;

   assign be_sel = hdr_q.ovr ? hdr_q.be : be_auto;
   assign hdr_we = (phase == PH_IDLE) && acc_fire && hit_hdr && acc_write;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         tl_write  <= 1'b0;
         tl_bus    <= '0;
         tl_devfn  <= '0;
         tl_regnum <= '0;
         tl_be     <= '0;
         tl_wdata  <= '0;
         rsp_data  <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (acc_fire) begin
                  if (hit_win) begin
                     phase     <= PH_WAIT;
                     tl_write  <= acc_write;
                     tl_bus    <= hdr_q.bus;
                     tl_devfn  <= hdr_q.devfn;
                     tl_regnum <= acc_regnum;
                     tl_be     <= be_sel;
                     tl_wdata  <= wdata_al;
                  end else begin
                     phase    <= PH_RESP;
                     rsp_data <= (hit_hdr && !acc_write) ? hdr_view : '0;
                  end
               end
            end
            PH_WAIT: begin
               if (tl_done) begin
                  phase    <= PH_RESP;
                  rsp_data <= tl_write ? '0 : tl_rdata;
               end
            end
            PH_RESP: phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cfghdr_fmt.sv
module cfghdr_fmt
   import cfghdr_pkg::*;
#(
   parameter int ADDR_W   = 13,
   parameter int DATA_W   = 32,
   parameter int HDR_OFS  = 32'h140,
   parameter int WIN_BASE = 32'h1000,
   parameter int WIN_BITS = 12,
   localparam int NLANE    = DATA_W / 8,
   localparam int IDX_W    = $clog2(NLANE),
   localparam int REGNUM_W = WIN_BITS - IDX_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rb_valid,
   input  logic                rb_write,
   input  logic [ADDR_W-1:0]   rb_addr,
   input  logic [SIZE_W-1:0]   rb_size,
   input  logic [DATA_W-1:0]   rb_wdata,
   output logic                rb_ready,
   output logic                rb_done,
   output logic [DATA_W-1:0]   rb_rdata,
   output logic                tl_req,
   output logic                tl_write,
   output logic [7:0]          tl_bus,
   output logic [7:0]          tl_devfn,
   output logic [REGNUM_W-1:0] tl_regnum,
   output logic [NLANE-1:0]    tl_first_be,
   output logic [DATA_W-1:0]   tl_wdata,
   input  logic                tl_done,
   input  logic [DATA_W-1:0]   tl_rdata
);

   localparam int WIN_TAG_W = ADDR_W - WIN_BITS;
   localparam logic [WIN_TAG_W-1:0] WIN_TAG = WIN_TAG_W'(WIN_BASE >> WIN_BITS);
   localparam logic [ADDR_W-1:0]    HDR_ADDR = ADDR_W'(HDR_OFS);

   // Elaboration checks on the parameter set.
   if (DATA_W != 32) begin : g_bad_data_w
      $error("cfghdr_fmt: DATA_W must be 32, first-dword enables are 4 bits");
   end
   if (WIN_BITS >= ADDR_W) begin : g_bad_win_bits
      $error("cfghdr_fmt: window must leave at least one tag bit in the address");
   end
   if ((WIN_BASE % (1 << WIN_BITS)) != 0) begin : g_bad_win_align
      $error("cfghdr_fmt: window base must be aligned to the window size");
   end
   if ((HDR_OFS >> WIN_BITS) == (WIN_BASE >> WIN_BITS)) begin : g_bad_hdr_ofs
      $error("cfghdr_fmt: routing register must lie outside the window");
   end

   hdr_t                hdr_q;
   logic [DATA_W-1:0]   hdr_view;
   logic                hdr_we;
   logic                hit_hdr;
   logic                hit_win;
   logic                acc_fire;
   logic [NLANE-1:0]    be_auto;
   logic [DATA_W-1:0]   wdata_al;
   phase_e              phase;

   assign hit_hdr  = (rb_addr == HDR_ADDR);
   assign hit_win  = (rb_addr[ADDR_W-1:WIN_BITS] == WIN_TAG);
   assign acc_fire = rb_valid && rb_ready;

   assign rb_ready = (phase == PH_IDLE);
   assign tl_req   = (phase == PH_WAIT);
   assign rb_done  = (phase == PH_RESP);

   cfghdr_reg #(
      .DATA_W (DATA_W)
   ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (hdr_we),
      .wr_data (rb_wdata[HDR_USED_W-1:0]),
      .hdr_q   (hdr_q),
      .rd_view (hdr_view)
   );

   cfghdr_lane #(
      .NLANE  (NLANE),
      .IDX_W  (IDX_W),
      .SIZE_W (SIZE_W)
   ) u_lane (
      .acc_size  (rb_size),
      .acc_lo    (rb_addr[IDX_W-1:0]),
      .acc_wdata (rb_wdata),
      .be_auto   (be_auto),
      .wdata_al  (wdata_al)
   );

   cfghdr_ctl #(
      .DATA_W   (DATA_W),
      .NLANE    (NLANE),
      .REGNUM_W (REGNUM_W)
   ) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_fire   (acc_fire),
      .hit_hdr    (hit_hdr),
      .hit_win    (hit_win),
      .acc_write  (rb_write),
      .acc_regnum (rb_addr[WIN_BITS-1:IDX_W]),
      .hdr_q      (hdr_q),
      .hdr_view   (hdr_view),
      .be_auto    (be_auto),
      .wdata_al   (wdata_al),
      .tl_done    (tl_done),
      .tl_rdata   (tl_rdata),
      .phase      (phase),
      .hdr_we     (hdr_we),
      .tl_write   (tl_write),
      .tl_bus     (tl_bus),
      .tl_devfn   (tl_devfn),
      .tl_regnum  (tl_regnum),
      .tl_be      (tl_first_be),
      .tl_wdata   (tl_wdata),
      .rsp_data   (rb_rdata)
   );

endmodule

// File: rtl/cfghdr_fmt_chk.sv
module cfghdr_fmt_chk
   import cfghdr_pkg::*;
#(
   parameter int ADDR_W   = 13,
   parameter int HDR_OFS  = 32'h140,
   parameter int WIN_BASE = 32'h1000,
   parameter int WIN_BITS = 12,
   parameter int REGNUM_W = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rb_valid,
   input logic [ADDR_W-1:0]   rb_addr,
   input logic                rb_ready,
   input logic                rb_done,
   input logic                tl_req,
   input logic                tl_done,
   input logic [7:0]          tl_bus,
   input logic [7:0]          tl_devfn,
   input logic [REGNUM_W-1:0] tl_regnum,
   input logic [3:0]          tl_first_be,
   input logic [31:0]         tl_wdata,
   input hdr_t                hdr_q
);

   localparam int WIN_TAG_W = ADDR_W - WIN_BITS;
   localparam logic [WIN_TAG_W-1:0] WIN_TAG  = WIN_TAG_W'(WIN_BASE >> WIN_BITS);
   localparam logic [ADDR_W-1:0]    HDR_ADDR = ADDR_W'(HDR_OFS);

   logic win_acc;
   logic hdr_acc;
   assign win_acc = rb_valid && rb_ready && (rb_addr[ADDR_W-1:WIN_BITS] == WIN_TAG);
   assign hdr_acc = rb_valid && rb_ready && (rb_addr == HDR_ADDR);

   AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({rb_ready, tl_req, rb_done}) == 1);  // R8

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tl_req && !tl_done |=> tl_req && $stable(tl_regnum) && $stable(tl_first_be)
                             && $stable(tl_wdata) && $stable(tl_bus) && $stable(tl_devfn));  // R8

   AST_WIN_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      win_acc |=> tl_req);  // R3

   AST_WIN_REGNUM: assert property (@(posedge clk) disable iff (!rst_n)
      win_acc |=> tl_regnum == $past(rb_addr[WIN_BITS-1:2]));  // R3

   AST_WIN_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      win_acc |=> tl_bus == $past(hdr_q.bus) && tl_devfn == $past(hdr_q.devfn));  // R3

   AST_OVR_BE: assert property (@(posedge clk) disable iff (!rst_n)
      win_acc && hdr_q.ovr |=> tl_first_be == $past(hdr_q.be));  // R5

   AST_TL_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      tl_req && tl_done |=> rb_done);  // R7

   AST_HDR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_acc |=> rb_done);  // R10

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rb_done |=> rb_ready && !rb_done);  // R10

endmodule

bind cfghdr_fmt cfghdr_fmt_chk #(
   .ADDR_W   (ADDR_W),
   .HDR_OFS  (HDR_OFS),
   .WIN_BASE (WIN_BASE),
   .WIN_BITS (WIN_BITS),
   .REGNUM_W (REGNUM_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rb_valid    (rb_valid),
   .rb_addr     (rb_addr),
   .rb_ready    (rb_ready),
   .rb_done     (rb_done),
   .tl_req      (tl_req),
   .tl_done     (tl_done),
   .tl_bus      (tl_bus),
   .tl_devfn    (tl_devfn),
   .tl_regnum   (tl_regnum),
   .tl_first_be (tl_first_be),
   .tl_wdata    (tl_wdata),
   .hdr_q       (hdr_q)
);

// File: tb/sim_cfghdr_fmt.sv
module sim_cfghdr_fmt;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rb_valid = 1'b0;
   logic        rb_write = 1'b0;
   logic [12:0] rb_addr = '0;
   logic [2:0]  rb_size = '0;
   logic [31:0] rb_wdata = '0;
   logic        rb_ready;
   logic        rb_done;
   logic [31:0] rb_rdata;
   logic        tl_req;
   logic        tl_write;
   logic [7:0]  tl_bus;
   logic [7:0]  tl_devfn;
   logic [9:0]  tl_regnum;
   logic [3:0]  tl_first_be;
   logic [31:0] tl_wdata;
   logic        tl_done = 1'b0;
   logic [31:0] tl_rdata = '0;

   always #4 clk = ~clk;

   cfghdr_fmt u0 (
      .clk(clk), .rst_n(rst_n), .rb_valid(rb_valid), .rb_write(rb_write),
      .rb_addr(rb_addr), .rb_size(rb_size), .rb_wdata(rb_wdata),
      .rb_ready(rb_ready), .rb_done(rb_done), .rb_rdata(rb_rdata),
      .tl_req(tl_req), .tl_write(tl_write), .tl_bus(tl_bus), .tl_devfn(tl_devfn),
      .tl_regnum(tl_regnum), .tl_first_be(tl_first_be), .tl_wdata(tl_wdata),
      .tl_done(tl_done), .tl_rdata(tl_rdata)
   );

   typedef struct {
      logic        wr;
      logic [7:0]  bus;
      logic [7:0]  devfn;
      logic [9:0]  regnum;
      logic [3:0]  be;
      string       be_tag;
      logic [31:0] wdata;
      logic [31:0] rdata;
   } tl_item_t;

   tl_item_t    tl_q[$];
   logic [31:0] rsp_q[$];
   string       rsp_tag_q[$];

   int   checks = 0;
   int   errors = 0;
   bit   ended  = 0;
   logic [20:0] hdr_m = '0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_be(input logic [2:0] size, input logic [1:0] lo,
                                         input logic [20:0] hdr);
      logic [3:0] m;
      if (hdr[20]) return hdr[19:16];
      m = '0;
      for (int i = 0; i < 4; i++)
         if (i >= int'(lo) && i < int'(lo) + int'(size)) m[i] = 1'b1;
      return m;
   endfunction

   function automatic logic [31:0] exp_wd(input logic [2:0] size, input logic [1:0] lo,
                                          input logic [31:0] wd);
      if (size <= 3'd2) return wd << (8 * int'(lo));
      return wd;
   endfunction

   // Driver: computes expected items, pushes them, then presents the access.
   task automatic access(input logic wr, input logic [12:0] addr, input logic [2:0] size,
                         input logic [31:0] wd, input logic [31:0] tlrd, input string tag);
      tl_item_t it;
      logic     win;
      win = addr[12];
      if (win) begin
         it.wr = wr; it.bus = hdr_m[15:8]; it.devfn = hdr_m[7:0];
         it.regnum = addr[11:2]; it.be = exp_be(size, addr[1:0], hdr_m);
         it.be_tag = hdr_m[20] ? "R5 override enables" : "R4 derived enables";
         it.wdata = exp_wd(size, addr[1:0], wd); it.rdata = tlrd;
         tl_q.push_back(it);
         rsp_q.push_back(wr ? 32'h0 : tlrd);
      end else if (addr == 13'h140) begin
         rsp_q.push_back(wr ? 32'h0 : {11'h0, hdr_m});
         if (wr) hdr_m = wd[20:0];
      end else begin
         rsp_q.push_back(32'h0);
      end
      rsp_tag_q.push_back(tag);
      @(negedge clk);
      while (!rb_ready) @(negedge clk);
      rb_valid = 1'b1; rb_write = wr; rb_addr = addr; rb_size = size; rb_wdata = wd;
      @(negedge clk);
      rb_valid = 1'b0; rb_wdata = 32'hA5A5_5A5A;
      chk("R8 ready low after accept", {31'h0, rb_ready}, 32'h0);
      if (win) chk("R3 request raised after accept", {31'h0, tl_req}, 32'h1);
      else     chk("R10 local completion", {31'h0, rb_done}, 32'h1);
      while (!rb_ready) @(negedge clk);
   endtask

   // Transaction-layer responder and request monitor.
   int dly_seed = 0;
   initial begin
      tl_item_t it;
      forever begin
         @(negedge clk);
         if (tl_req) begin
            if (tl_q.size() == 0) begin
               chk("R3 unexpected request", 32'h1, 32'h0);
            end else begin
               it = tl_q.pop_front();
               chk("R3 write flag", {31'h0, tl_write}, {31'h0, it.wr});
               chk("R3 bus", {24'h0, tl_bus}, {24'h0, it.bus});
               chk("R3 devfn", {24'h0, tl_devfn}, {24'h0, it.devfn});
               chk("R3 regnum", {22'h0, tl_regnum}, {22'h0, it.regnum});
               chk(it.be_tag, {28'h0, tl_first_be}, {28'h0, it.be});
               chk("R6 lane data", tl_wdata, it.wdata);
               dly_seed++;
               repeat (dly_seed % 3) begin
                  @(negedge clk);
                  chk("R8 request held", {30'h0, tl_req, rb_ready}, 32'h2);
               end
               tl_done = 1'b1; tl_rdata = it.rdata;
               @(negedge clk);
               tl_done = 1'b0; tl_rdata = 32'hDEAD_BEEF;
            end
         end
      end
   end

   // Response monitor.
   initial begin
      logic [31:0] e;
      string       t;
      forever begin
         @(negedge clk);
         if (rb_done) begin
            if (rsp_q.size() == 0) begin
               chk("R7 unexpected completion", 32'h1, 32'h0);
            end else begin
               e = rsp_q.pop_front();
               t = rsp_tag_q.pop_front();
               chk(t, rb_rdata, e);
            end
         end
      end
   end

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset ready", {31'h0, rb_ready}, 32'h1);
      chk("R1 reset request", {30'h0, tl_req, rb_done}, 32'h0);
      rst_n = 1'b1;
      access(1'b0, 13'h140, 3'd4, 32'h0, 32'h0, "R1 routing register zero");
      access(1'b1, 13'h140, 3'd4, 32'hFFFF_FFFF, 32'h0, "R2 write completion");
      access(1'b0, 13'h140, 3'd4, 32'h0, 32'h0, "R2 upper bits zero");
      access(1'b1, 13'h140, 3'd4, 32'h0003_1A2B, 32'h0, "R2 write completion");
      access(1'b0, 13'h140, 3'd4, 32'h0, 32'h0, "R2 readback");
      // derived enables and full dword reads
      access(1'b0, 13'h1000, 3'd4, 32'h0, 32'h1234_5678, "R7 dword read data");
      access(1'b0, 13'h1FFC, 3'd4, 32'h0, 32'hCAFE_F00D, "R7 top of window read");
      for (int o = 0; o < 4; o++)
         access(1'b0, 13'h1040 + 13'(o), 3'd1, 32'h0, 32'h0BAD_0000 + o, "R7 byte read");
      for (int o = 0; o < 4; o++)
         access(1'b0, 13'h1084 + 13'(o), 3'd2, 32'h0, 32'h5555_0000 + o, "R7 half read");
      // narrow and full writes
      for (int o = 0; o < 4; o++)
         access(1'b1, 13'h1100 + 13'(o), 3'd1, 32'h0000_00C3, 32'h7777_7777, "R7 write completes zero");
      for (int o = 0; o < 4; o++)
         access(1'b1, 13'h1208 + 13'(o), 3'd2, 32'h0000_9E4D, 32'h7777_7777, "R7 write completes zero");
      access(1'b1, 13'h1010, 3'd4, 32'h89AB_CDEF, 32'h0, "R6 full write completes");
      // override enables
      access(1'b1, 13'h140, 3'd4, 32'h0019_7711, 32'h0, "R5 program override");
      access(1'b1, 13'h1003, 3'd1, 32'h0000_0042, 32'h0, "R5 write completes");
      access(1'b0, 13'h1AB6, 3'd2, 32'h0, 32'h3141_5926, "R5 read data");
      // addresses outside both regions
      access(1'b1, 13'h0200, 3'd4, 32'h001F_FFFF, 32'h0, "R9 ignored write completes");
      access(1'b1, 13'h0144, 3'd4, 32'h0000_0000, 32'h0, "R9 ignored write completes");
      access(1'b0, 13'h0140, 3'd4, 32'h0, 32'h0, "R9 routing register unchanged");
      access(1'b0, 13'h0200, 3'd4, 32'h0, 32'h0, "R9 unmapped read zero");
      repeat (4) @(negedge clk);
      chk("R7 all requests answered", tl_q.size(), 32'h0);
      chk("R7 all completions seen", rsp_q.size(), 32'h0);
      finish_run();
   end

endmodule